// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a processor core that completes one instruction per clock for a small 32-bit load/store instruction set. Each cycle, the program counter addresses an instruction-memory read port. The returned word is decoded, and two source registers are read from a 32-entry register file. An ALU then forms either a result, a memory address or a comparison. At the rising clock edge, the core commits the result to the register file or to data memory and loads the next program counter.

Both memories sit outside the core. Each has a combinational read port. Data memory also has a write port that the environment samples on the rising edge while the write strobe is high. The supported operations are word load and store, add, subtract, bitwise AND and OR, signed set-on-less-than, branch on equal and unconditional jump. Every operation except the jump passes through the ALU after the register read.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the program counter, seen on imem_addr, to 0 and clears every register.
- R2: An instruction that is neither a taken branch nor a jump advances imem_addr by 4 at the next rising edge.
- R3: Register-format instructions (opcode 0x00) take rs from bits [25:21], rt from [20:16] and rd from [15:11], and write rd with add (funct 0x20), subtract rs-rt (0x22), AND (0x24) or OR (0x25).
- R4: Set-on-less-than (funct 0x2A) writes 1 to rd when rs < rt as signed two's-complement values, and 0 otherwise.
- R5: A load (opcode 0x23) presents rs + sign-extended bits [15:0] on dmem_addr and writes dmem_rdata into rt.
- R6: A store (opcode 0x2B) raises dmem_we, presents rs + sign-extended offset on dmem_addr and the rt value on dmem_wdata, and writes no register.
- R7: Branch-on-equal (opcode 0x04) compares rs and rt with an ALU subtraction. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2. Otherwise it is PC+4.
- R8: A jump (opcode 0x02) loads the PC with bits [31:28] of PC+4, followed by bits [25:0] of the instruction, followed by two zero bits.
- R9: Register 0 always reads as zero, and any write to it is discarded.
- R10: dmem_we is high only while a store is executing outside reset. Loads, ALU operations, branches and jumps leave memory untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Program counter, byte address of the instruction |
| imem_data | input | 32 | Instruction word returned combinationally |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled by memory at the rising edge |
| dmem_rdata | input | 32 | Load data returned combinationally |

## Verification
The bound checker checks the following on every cycle: the PC step of 4, both outcomes of branch-on-equal, the jump target, the store address and data, the confinement of the write strobe to stores, and the zero read of register 0. Results written into the register file can only be seen through a later store. The bench therefore runs short programs that load operands, compute, and store the results. This shows the ALU arithmetic, signed comparison, load sign extension, discarded writes to register 0 and skipped instructions. Only these scenarios can show that a value reached the right register.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    mem_to_reg;
    logic    mem_we;
    logic    use_imm;
    logic    is_beq;
    logic    is_jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] y;
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
    return y;
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc4,
                                                  input logic [15:0] off);
    return pc4 + {sext16(off)[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc4,
                                                input logic [25:0] idx);
    return {pc4[XLEN-1:XLEN-4], idx, 2'b00};
  endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [31:0]       instr,
  output ctrl_t             ctrl,
  output logic [REG_AW-1:0] rs,
  output logic [REG_AW-1:0] rt,
  output logic [REG_AW-1:0] rd,
  output logic [15:0]       imm,
  output logic [25:0]       jidx
);
  logic [5:0] opcode;
  logic [5:0] funct;
  logic       unused_shamt;

  assign opcode       = instr[31:26];
  assign funct        = instr[5:0];
  assign rs           = instr[25:21];
  assign rt           = instr[20:16];
  assign rd           = instr[15:11];
  assign imm          = instr[15:0];
  assign jidx         = instr[25:0];
  assign unused_shamt = ^instr[10:6];

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.reg_we     = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.use_imm    = 1'b1;
      end
      OP_STORE: begin
        ctrl.mem_we  = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_beq = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_JUMP: ctrl.is_jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  assign y    = alu_eval(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  logic [XLEN-1:0]   pc_q;
  logic [XLEN-1:0]   pc_plus4;
  logic [XLEN-1:0]   pc_next;
  ctrl_t             ctrl;
  logic [REG_AW-1:0] rs_idx;
  logic [REG_AW-1:0] rt_idx;
  logic [REG_AW-1:0] rd_idx;
  logic [15:0]       imm16;
  logic [25:0]       jfield;
  logic [XLEN-1:0]   rs_val;
  logic [XLEN-1:0]   rt_val;
  logic [XLEN-1:0]   alu_b;
  logic [XLEN-1:0]   alu_y;
  logic              alu_zero;

  // Named events, visible to the bound checker
  logic              ev_reg_write;
  logic              ev_branch_taken;
  logic              ev_jump;
  logic [REG_AW-1:0] wb_addr;
  logic [XLEN-1:0]   wb_data;

  sc_decode u_dec (
    .instr (imem_data),
    .ctrl  (ctrl),
    .rs    (rs_idx),
    .rt    (rt_idx),
    .rd    (rd_idx),
    .imm   (imm16),
    .jidx  (jfield)
  );

  sc_regfile #(.DW(XLEN), .AW(REG_AW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (ev_reg_write),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (rs_idx),
    .raddr_b (rt_idx),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign alu_b = ctrl.use_imm ? sext16(imm16) : rt_val;

  sc_alu u_alu (
    .op   (ctrl.alu_op),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign pc_plus4        = pc_q + 32'd4;
  assign ev_jump         = ctrl.is_jump;
  assign ev_branch_taken = ctrl.is_beq & alu_zero;
  assign wb_addr         = ctrl.dst_rd ? rd_idx : rt_idx;
  assign wb_data         = ctrl.mem_to_reg ? dmem_rdata : alu_y;
  assign ev_reg_write    = ctrl.reg_we & ~rst;

  always_comb begin
    if (ev_jump)              pc_next = jump_dest(pc_plus4, jfield);
    else if (ev_branch_taken) pc_next = branch_dest(pc_plus4, imm16);
    else                      pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we & ~rst;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        dmem_we,
  input logic [31:0] dmem_addr,
  input logic [31:0] dmem_wdata,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val
);
  logic [5:0]  op;
  logic [31:0] step;
  logic [31:0] offs;
  logic [31:0] br_tgt;
  logic [31:0] jp_tgt;

  assign op     = instr[31:26];
  assign step   = pc + 32'd4;
  assign offs   = {{16{instr[15]}}, instr[15:0]};
  assign br_tgt = step + (offs << 2);
  assign jp_tgt = {step[31:28], instr[25:0], 2'b00};

  a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc == 32'h0);

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (op != OP_BEQ && op != OP_JUMP) |=> pc == $past(pc) + 32'd4);

  a_r7_beq_taken: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ && rs_val == rt_val) |=> pc == $past(br_tgt));

  a_r7_beq_fall: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

  a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JUMP) |=> pc == $past(jp_tgt));

  a_r6_store_port: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (dmem_addr == rs_val + offs && dmem_wdata == rt_val));

  a_r10_store_only: assert property (@(posedge clk) disable iff (rst)
    (op != OP_STORE) |-> !dmem_we);

  a_r9_zero_read: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> rs_val == 32'h0);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pc         (imem_addr),
  .instr      (imem_data),
  .dmem_we    (dmem_we),
  .dmem_addr  (dmem_addr),
  .dmem_wdata (dmem_wdata),
  .rs_val     (rs_val),
  .rt_val     (rt_val)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sc_core u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int idx);
    return {6'h02, idx[25:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
  endtask

  task automatic release_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset_and_step();
    begin_prog();
    release_reset();
    check("R1 pc after reset", imem_addr, 32'h0);
    run(1);
    check("R2 pc step 1", imem_addr, 32'h4);
    run(2);
    check("R2 pc step 3", imem_addr, 32'hC);
    @(negedge clk) rst = 1'b1;
    run(1);
    check("R1 mid-run reset", imem_addr, 32'h0);
  endtask

  task automatic t_alu(logic [31:0] a, logic [31:0] b);
    logic [31:0] lt_ab, lt_ba;
    lt_ab = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    lt_ba = ($signed(b) < $signed(a)) ? 32'd1 : 32'd0;
    begin_prog();
    dmem[0] = a; dmem[1] = b;
    imem[0] = enc_i(6'h23, 0, 1, 0);
    imem[1] = enc_i(6'h23, 0, 2, 4);
    imem[2] = enc_r(1, 2, 3, 6'h20);
    imem[3] = enc_r(1, 2, 4, 6'h22);
    imem[4] = enc_r(1, 2, 5, 6'h24);
    imem[5] = enc_r(1, 2, 6, 6'h25);
    imem[6] = enc_r(1, 2, 7, 6'h2A);
    imem[7] = enc_r(2, 1, 8, 6'h2A);
    for (int k = 0; k < 6; k++) imem[8+k] = enc_i(6'h2B, 0, 3+k, 16+4*k);
    release_reset();
    run(14);
    check("R3 add", dmem[4], a + b);
    check("R3 sub", dmem[5], a - b);
    check("R3 and", dmem[6], a & b);
    check("R3 or",  dmem[7], a | b);
    check("R4 slt a<b", dmem[8], lt_ab);
    check("R4 slt b<a", dmem[9], lt_ba);
  endtask

  task automatic t_zero_reg(logic [31:0] a, logic [31:0] b);
    begin_prog();
    dmem[0] = a; dmem[1] = b;
    imem[0] = enc_i(6'h23, 0, 1, 0);
    imem[1] = enc_i(6'h23, 0, 2, 4);
    imem[2] = enc_r(1, 2, 0, 6'h20);
    imem[3] = enc_i(6'h2B, 0, 0, 40);
    imem[4] = enc_i(6'h23, 0, 0, 0);
    imem[5] = enc_i(6'h2B, 0, 0, 44);
    imem[6] = enc_i(6'h2B, 0, 1, 48);
    release_reset();
    run(7);
    check("R9 add into r0", dmem[10], 32'h0);
    check("R9 load into r0", dmem[11], 32'h0);
    check("R5 load then store", dmem[12], a);
  endtask

  task automatic t_neg_offset();
    begin_prog();
    dmem[2]  = 32'd64;
    dmem[14] = 32'hCAFE1234;
    imem[0] = enc_i(6'h23, 0, 1, 8);
    imem[1] = enc_i(6'h23, 1, 2, -8);
    imem[2] = enc_i(6'h2B, 1, 2, -4);
    release_reset();
    run(3);
    check("R5 negative offset", dmem[15], 32'hCAFE1234);
  endtask

  task automatic t_store_port(logic [31:0] a);
    begin_prog();
    dmem[0] = a;
    imem[0] = enc_i(6'h23, 0, 1, 0);
    imem[1] = enc_i(6'h2B, 0, 1, 8);
    release_reset();
    #1;
    check("R10 no strobe on load", {31'd0, dmem_we}, 32'h0);
    run(1);
    check("R6 strobe on store", {31'd0, dmem_we}, 32'h1);
    check("R6 store address", dmem_addr, 32'h8);
    check("R6 store data", dmem_wdata, a);
  endtask

  task automatic t_beq(logic [31:0] a, logic [31:0] b);
    begin_prog();
    dmem[0] = a; dmem[1] = b;
    imem[0] = enc_i(6'h23, 0, 1, 0);
    imem[1] = enc_i(6'h23, 0, 2, 4);
    imem[2] = enc_i(6'h04, 1, 2, 1);
    imem[3] = enc_i(6'h2B, 0, 1, 52);
    imem[4] = enc_i(6'h2B, 0, 2, 56);
    release_reset();
    run(3);
    check("R7 beq next pc", imem_addr, (a == b) ? 32'h10 : 32'hC);
    run(2);
    check("R7 skipped store", dmem[13], (a == b) ? 32'h0 : a);
    check("R7 landing store", dmem[14], b);
  endtask

  task automatic t_jump(logic [31:0] a);
    begin_prog();
    dmem[0] = a;
    imem[0]  = enc_i(6'h23, 0, 1, 0);
    imem[1]  = enc_j(10);
    imem[2]  = enc_i(6'h2B, 0, 1, 60);
    imem[10] = enc_i(6'h2B, 0, 1, 64);
    release_reset();
    run(2);
    check("R8 jump target", imem_addr, 32'd40);
    run(2);
    check("R8 skipped store", dmem[15], 32'h0);
    check("R8 target store", dmem[16], a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_and_step();
    t_alu(32'd7, 32'd5);
    t_alu(32'hFFFFFFFD, 32'd4);
    t_alu(32'h80000000, 32'h7FFFFFFF);
    t_alu(32'd9, 32'd9);
    t_zero_reg(32'h12345678, 32'h00000011);
    t_neg_offset();
    t_store_port(32'hA5A5_0F0F);
    t_beq(32'd33, 32'd33);
    t_beq(32'd33, 32'd34);
    t_jump(32'h0BAD_F00D);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule